// File: doc/BRIEF.md
# Signed divide and modulo unit

This block is a multi-cycle integer divider. It returns one of four results: the truncating quotient, the truncating remainder, the floor quotient or the floor modulo. Each operand comes with its own signedness flag. The pair is treated as signed only when both flags are set. Otherwise both operands are taken as unsigned.

A single unsigned restoring core does the arithmetic and produces one quotient bit per clock. Sign handling sits around the core:
- **Before the core:** magnitudes, a divisor-driven negation, and a one's-complement fold of a negative dividend.
- **After the core:** negation, complement and a divisor-minus-remainder correction.

The result is brought to a parameterised output width.

A caller drives the operands, flags and mode, then raises `start` for one cycle while `busy` is low. `busy` then stays high for a fixed number of cycles. `done` pulses for one cycle, and `y` carries the new result from that cycle until the next result replaces it.

Top module: `divmod_unit`

## Requirements
- R1: Both operands are first widened to W = max(A_W, B_W) bits. They are sign-extended only when `a_signed` and `b_signed` are both 1. In every other flag combination both are zero-extended and the operation is unsigned.
- R2: After reset, `busy`, `done` and `y` are 0. A `start` seen while `busy` is 0 makes `busy` go high on the next cycle and stay high for exactly W+2 cycles. `done` is high for exactly one cycle, the cycle in which `busy` has just dropped. `y` changes only in a cycle where `done` is high.
- R3: Mode 2'b00 (truncating quotient), signed: the result is a/b rounded toward zero.
- R4: Mode 2'b01 (truncating remainder), signed: the result is a - b*trunc(a/b), so it carries the dividend's sign.
- R5: Mode 2'b10 (floor quotient), signed: the result is a/b rounded toward minus infinity.
- R6: Mode 2'b11 (floor modulo), signed: the result is a - b*floor(a/b), so it carries the divisor's sign.
- R7: In unsigned operation, modes 2'b00 and 2'b10 both give the unsigned quotient, and modes 2'b01 and 2'b11 both give the unsigned remainder.
- R8: A zero divisor takes the normal cycle count.
  - Both remainder modes return the W-bit dividend.
  - Unsigned quotient modes return all ones.
  - Signed mode 2'b00 returns -1 for a dividend >= 0 and +1 for a negative one.
  - Signed mode 2'b10 returns -1 for a dividend >= 0 and 0 for a negative one.
- R9: The W-bit result is brought to Y_W bits by sign extension in signed operation and by zero extension in unsigned operation.
- R10: Results are kept modulo 2^W before resizing. The most negative dividend is handled exactly: for example -2^(W-1) divided by -1 gives -2^(W-1), and -2^(W-1) divided by -2^(W-1) gives 1 in floor mode.
- R11: A `start` raised while `busy` is high is ignored. The running operation completes with its own operands and its normal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; operands are captured on this cycle |
| a | input | A_W | Dividend |
| b | input | B_W | Divisor |
| a_signed | input | 1 | Dividend signedness flag |
| b_signed | input | 1 | Divisor signedness flag |
| mode | input | 2 | 00 trunc quotient, 01 trunc remainder, 10 floor quotient, 11 floor modulo |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; result valid |
| y | output | Y_W | Result, held until the next result |

## Verification
On every cycle, the bound checker enforces the handshake:
- an accepted start raises `busy`;
- `busy` lasts exactly W+2 cycles;
- `done` is a lone pulse that never overlaps `busy`;
- `y` changes only with `done`.

The checker also enforces the zero-divisor cases that can be read off the captured operands: the remainder equals the dividend, and the unsigned quotient is all ones.

The arithmetic of the four modes can only be shown by the bench's scenarios. These cover the sign combinations, the most negative dividend and divisor, wrap-around of -2^(W-1)/-1, extension to the output width, and a start that arrives mid-operation and must be ignored.

// File: rtl/divmod_pkg.sv
`timescale 1ns/1ps
package divmod_pkg;

   typedef enum logic [1:0] {
      DM_TQUO = 2'b00,
      DM_TREM = 2'b01,
      DM_FQUO = 2'b10,
      DM_FMOD = 2'b11
   } dm_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_RUN,
      ST_FIN,
      ST_DONE
   } dm_state_e;

   function automatic int dm_max(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/divmod_pre.sv
`timescale 1ns/1ps
// Operand conditioning ahead of the unsigned core.
module divmod_pre
   import divmod_pkg::*;
#(
   parameter int A_W = 8,
   parameter int B_W = 8,
   parameter int W   = 8
) (
   input  dm_mode_e         mode,
   input  logic [A_W-1:0]   a,
   input  logic [B_W-1:0]   b,
   input  logic             a_sgn,
   input  logic             b_sgn,
   output logic [W-1:0]     num,
   output logic [W-1:0]     den,
   output logic             sgn,
   output logic             neg_a,
   output logic             neg_b,
   output logic             inv_q
);

   logic [W-1:0] ax, bx;
   logic [W-1:0] mag_a, mag_b;
   logic [W:0]   ax_wide, fl_a;
   logic [W-1:0] fl_b, fl_num;
   logic         b_neg;

   assign sgn = a_sgn & b_sgn;

   // Widen each operand to the common width; the variant depends on
   // whether that operand is already the wide one.
   generate
      if (A_W < W) begin : g_a_ext
         assign ax = {{(W-A_W){sgn & a[A_W-1]}}, a};
      end else begin : g_a_same
         assign ax = a;
      end
      if (B_W < W) begin : g_b_ext
         assign bx = {{(W-B_W){sgn & b[B_W-1]}}, b};
      end else begin : g_b_same
         assign bx = b;
      end
   endgenerate

   assign neg_a = sgn & ax[W-1];
   assign neg_b = sgn & bx[W-1];
   assign b_neg = neg_b;

   // Magnitudes as unsigned W-bit values (the most negative value maps
   // to 2^(W-1), which is representable unsigned).
   assign mag_a = neg_a ? (~ax + W'(1)) : ax;
   assign mag_b = neg_b ? (~bx + W'(1)) : bx;

   // Floor-quotient path: flip both signs on a negative divisor, then
   // fold a negative dividend with one's complement. The dividend is held
   // one bit wider so negating the most negative value cannot wrap.
   assign ax_wide = {neg_a, ax};
   assign fl_a    = b_neg ? (~ax_wide + (W+1)'(1)) : ax_wide;
   assign fl_b    = b_neg ? (~bx + W'(1)) : bx;
   assign fl_num  = fl_a[W] ? ~fl_a[W-1:0] : fl_a[W-1:0];
   assign inv_q   = sgn & fl_a[W];

   always_comb begin
      if (!sgn) begin
         num = ax;
         den = bx;
      end else if (mode == DM_FQUO) begin
         num = fl_num;
         den = fl_b;
      end else begin
         num = mag_a;
         den = mag_b;
      end
   end

endmodule

// File: rtl/divmod_core.sv
`timescale 1ns/1ps
// Unsigned restoring divider, one quotient bit per step.
module divmod_core #(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   num,
   input  logic [W-1:0]   den,
   output logic [W-1:0]   quo,
   output logic [W-1:0]   rem,
   output logic [W-1:0]   dvs
);

   logic [W:0] shifted;
   logic [W:0] trial;
   logic       fits;

   assign shifted = {rem, quo[W-1]};
   assign trial   = shifted - {1'b0, dvs};
   assign fits    = ~trial[W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo <= '0;
         rem <= '0;
         dvs <= '0;
      end else if (load) begin
         quo <= num;
         rem <= '0;
         dvs <= den;
      end else if (step) begin
         quo <= {quo[W-2:0], fits};
         rem <= fits ? trial[W-1:0] : shifted[W-1:0];
      end
   end

endmodule

// File: rtl/divmod_post.sv
`timescale 1ns/1ps
// Result reconstruction after the unsigned core, then output resize.
module divmod_post
   import divmod_pkg::*;
#(
   parameter int W   = 8,
   parameter int Y_W = 8
) (
   input  dm_mode_e         mode,
   input  logic             sgn,
   input  logic             neg_a,
   input  logic             neg_b,
   input  logic             inv_q,
   input  logic [W-1:0]     quo,
   input  logic [W-1:0]     rem,
   input  logic [W-1:0]     dvs,
   output logic [Y_W-1:0]   y
);

   logic [W-1:0] res;
   logic [W-1:0] wrap_r;
   logic         wrap;

   assign wrap   = (neg_a ^ neg_b) & (|rem);
   assign wrap_r = wrap ? (dvs - rem) : rem;

   always_comb begin
      if (!sgn) begin
         res = (mode == DM_TREM || mode == DM_FMOD) ? rem : quo;
      end else begin
         unique case (mode)
            DM_TQUO: res = (neg_a ^ neg_b) ? (~quo + W'(1)) : quo;
            DM_TREM: res = neg_a ? (~rem + W'(1)) : rem;
            DM_FQUO: res = inv_q ? ~quo : quo;
            default: res = neg_b ? (~wrap_r + W'(1)) : wrap_r;
         endcase
      end
   end

   generate
      if (Y_W > W) begin : g_y_ext
         assign y = {{(Y_W-W){sgn & res[W-1]}}, res};
      end else if (Y_W == W) begin : g_y_same
         assign y = res;
      end else begin : g_y_cut
         assign y = res[Y_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/divmod_unit.sv
`timescale 1ns/1ps
module divmod_unit
   import divmod_pkg::*;
#(
   parameter int A_W = 8,
   parameter int B_W = 8,
   parameter int Y_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [A_W-1:0]   a,
   input  logic [B_W-1:0]   b,
   input  logic             a_signed,
   input  logic             b_signed,
   input  logic [1:0]       mode,
   output logic             busy,
   output logic             done,
   output logic [Y_W-1:0]   y
);

   localparam int W    = dm_max(A_W, B_W);
   localparam int CW   = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("divmod_unit: operand width must be at least 2");
      end
      if (Y_W < 1 || Y_W > 64) begin : g_bad_y
         $error("divmod_unit: Y_W must lie in 1..64");
      end
   endgenerate

   dm_state_e      state_q;
   logic [CW-1:0]  cnt_q;
   logic [A_W-1:0] op_a;
   logic [B_W-1:0] op_b;
   logic           op_sa, op_sb;
   dm_mode_e       op_mode;
   logic           f_sgn, f_na, f_nb, f_inv;
   logic [Y_W-1:0] y_q;

   logic [W-1:0]   p_num, p_den;
   logic           p_sgn, p_na, p_nb, p_inv;
   logic [W-1:0]   c_quo, c_rem, c_dvs;
   logic [Y_W-1:0] post_y;
   logic           accept;

   assign accept = start & ((state_q == ST_IDLE) | (state_q == ST_DONE));

   divmod_pre #(.A_W(A_W), .B_W(B_W), .W(W)) u_pre (
      .mode  (op_mode),
      .a     (op_a),
      .b     (op_b),
      .a_sgn (op_sa),
      .b_sgn (op_sb),
      .num   (p_num),
      .den   (p_den),
      .sgn   (p_sgn),
      .neg_a (p_na),
      .neg_b (p_nb),
      .inv_q (p_inv)
   );

   divmod_core #(.W(W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (state_q == ST_PREP),
      .step  (state_q == ST_RUN),
      .num   (p_num),
      .den   (p_den),
      .quo   (c_quo),
      .rem   (c_rem),
      .dvs   (c_dvs)
   );

   divmod_post #(.W(W), .Y_W(Y_W)) u_post (
      .mode  (op_mode),
      .sgn   (f_sgn),
      .neg_a (f_na),
      .neg_b (f_nb),
      .inv_q (f_inv),
      .quo   (c_quo),
      .rem   (c_rem),
      .dvs   (c_dvs),
      .y     (post_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         op_a    <= '0;
         op_b    <= '0;
         op_sa   <= 1'b0;
         op_sb   <= 1'b0;
         op_mode <= DM_TQUO;
         f_sgn   <= 1'b0;
         f_na    <= 1'b0;
         f_nb    <= 1'b0;
         f_inv   <= 1'b0;
         y_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  op_a    <= a;
                  op_b    <= b;
                  op_sa   <= a_signed;
                  op_sb   <= b_signed;
                  op_mode <= dm_mode_e'(mode);
                  state_q <= ST_PREP;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_PREP: begin
               f_sgn   <= p_sgn;
               f_na    <= p_na;
               f_nb    <= p_nb;
               f_inv   <= p_inv;
               cnt_q   <= '0;
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (cnt_q == LAST) state_q <= ST_FIN;
               else               cnt_q   <= cnt_q + CW'(1);
            end
            ST_FIN: begin
               y_q     <= post_y;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q == ST_PREP) | (state_q == ST_RUN) | (state_q == ST_FIN);
   assign done = (state_q == ST_DONE);
   assign y    = y_q;

endmodule

// File: rtl/divmod_unit_chk.sv
`timescale 1ns/1ps
module divmod_unit_chk #(
   parameter int A_W = 8,
   parameter int B_W = 8,
   parameter int Y_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [A_W-1:0]   a,
   input logic [B_W-1:0]   b,
   input logic             a_signed,
   input logic             b_signed,
   input logic [1:0]       mode,
   input logic             busy,
   input logic             done,
   input logic [Y_W-1:0]   y
);

   localparam int W = (A_W > B_W) ? A_W : B_W;

   logic [A_W-1:0] la;
   logic           lb_zero;
   logic           lsgn;
   logic [1:0]     lmode;
   logic [7:0]     bcnt;

   function automatic logic [Y_W-1:0] dividend_as_y(input logic [A_W-1:0] v,
                                                    input logic s);
      logic [63:0] t;
      logic [63:0] u;
      t = 64'(v);
      if (s && v[A_W-1]) t = t | ~((64'd1 << A_W) - 64'd1);
      u = t & ((64'd1 << W) - 64'd1);
      if (s && u[W-1]) u = u | ~((64'd1 << W) - 64'd1);
      return u[Y_W-1:0];
   endfunction

   function automatic logic [Y_W-1:0] ones_as_y();
      logic [63:0] u;
      u = (64'd1 << W) - 64'd1;
      return u[Y_W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         la      <= '0;
         lb_zero <= 1'b0;
         lsgn    <= 1'b0;
         lmode   <= 2'b00;
         bcnt    <= '0;
      end else begin
         if (start && !busy) begin
            la      <= a;
            lb_zero <= (b == '0);
            lsgn    <= a_signed & b_signed;
            lmode   <= mode;
         end
         bcnt <= busy ? bcnt + 8'd1 : 8'd0;
      end
   end

   assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bcnt == 8'(W + 1)) |=> !busy);

   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(bcnt) == 8'(W + 1)));

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_y_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(y));

   assert_zero_rem_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lb_zero && lmode[0]) |-> (y == dividend_as_y(la, lsgn)));

   assert_zero_uquo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lb_zero && !lmode[0] && !lsgn) |-> (y == ones_as_y()));

endmodule

bind divmod_unit divmod_unit_chk #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .a        (a),
   .b        (b),
   .a_signed (a_signed),
   .b_signed (b_signed),
   .mode     (mode),
   .busy     (busy),
   .done     (done),
   .y        (y)
);

// File: tb/divmod_unit_bench.sv
`timescale 1ns/1ps
module divmod_unit_bench;

   localparam int A_W = 6;
   localparam int B_W = 6;
   localparam int Y_W = 8;
   localparam int W   = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [A_W-1:0] a = '0;
   logic [B_W-1:0] b = '0;
   logic           a_signed = 1'b0;
   logic           b_signed = 1'b0;
   logic [1:0]     mode = 2'b00;
   logic           busy, done;
   logic [Y_W-1:0] y;

   int n_vec = 0;
   int n_bad = 0;
   logic [Y_W-1:0] last_y;

   always #10 clk = ~clk;

   divmod_unit #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) u_divmod_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
      .a_signed(a_signed), .b_signed(b_signed), .mode(mode),
      .busy(busy), .done(done), .y(y)
   );

   function automatic logic [Y_W-1:0] ref_y(input logic [A_W-1:0] ia,
                                            input logic [B_W-1:0] ib,
                                            input logic sa, input logic sb,
                                            input logic [1:0] md);
      longint av, bv, q, r, res, rl;
      logic s;
      s  = sa & sb;
      av = longint'(ia);
      if (s && ia[A_W-1]) av = av - (longint'(1) << A_W);
      bv = longint'(ib);
      if (s && ib[B_W-1]) bv = bv - (longint'(1) << B_W);
      if (bv == 0) begin
         if (md[0])       res = av;
         else if (!s)     res = (longint'(1) << W) - 1;
         else if (md[1])  res = (av >= 0) ? -1 : 0;
         else             res = (av >= 0) ? -1 : 1;
      end else begin
         q = av / bv;
         r = av % bv;
         if (md[1] && r != 0 && ((av < 0) != (bv < 0))) begin
            q = q - 1;
            r = r + bv;
         end
         res = md[0] ? r : q;
      end
      rl = res & ((longint'(1) << W) - 1);
      if (s && rl[W-1]) rl = rl - (longint'(1) << W);
      return rl[Y_W-1:0];
   endfunction

   task automatic chk(input string req, input logic [Y_W-1:0] act,
                      input logic [Y_W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called on a falling edge; returns on the falling edge where done is seen.
   task automatic do_op(input logic [A_W-1:0] ia, input logic [B_W-1:0] ib,
                        input logic sa, input logic sb, input logic [1:0] md);
      a = ia; b = ib; a_signed = sa; b_signed = sb; mode = md;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      last_y = y;
   endtask

   task automatic op_chk(input string req, input logic [A_W-1:0] ia,
                         input logic [B_W-1:0] ib, input logic sa,
                         input logic sb, input logic [1:0] md);
      do_op(ia, ib, sa, sb, md);
      chk(req, last_y, ref_y(ia, ib, sa, sb, md));
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      string tag;
      int    nb;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: idle outputs after reset
      chk("R2 reset busy", Y_W'(busy), '0);
      chk("R2 reset done", Y_W'(done), '0);
      chk("R2 reset y", y, '0);

      // R2: busy length and done pulse
      a = 6'd25; b = 6'd4; a_signed = 1'b1; b_signed = 1'b1; mode = 2'b00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nb = 0;
      while (busy && nb < 100) begin nb++; @(negedge clk); end
      chk("R2 busy cycles", Y_W'(nb), Y_W'(W + 2));
      chk("R2 done high", Y_W'(done), Y_W'(1));
      chk("R3 first result", y, ref_y(6'd25, 6'd4, 1'b1, 1'b1, 2'b00));
      @(negedge clk);
      chk("R2 done one cycle", Y_W'(done), '0);

      // R11: start during busy is ignored
      a = 6'd20; b = 6'd3; a_signed = 1'b1; b_signed = 1'b1; mode = 2'b00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      a = 6'd7; b = 6'd1; mode = 2'b01; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nb = 3;
      while (!done && nb < 100) begin nb++; @(negedge clk); end
      chk("R11 result of first op", y, 8'h06);
      chk("R11 normal timing", Y_W'(nb), Y_W'(W + 3));
      @(negedge clk);

      // R9: extension to the output width
      do_op(6'h3B, 6'd1, 1'b1, 1'b1, 2'b00);
      chk("R9 sign extension", last_y, 8'hFB);
      do_op(6'h3B, 6'd1, 1'b0, 1'b0, 2'b00);
      chk("R9 zero extension", last_y, 8'h3B);

      // R10: most negative operand corners
      do_op(6'h20, 6'h3F, 1'b1, 1'b1, 2'b00);
      chk("R10 min div -1", last_y, 8'hE0);
      do_op(6'h20, 6'h20, 1'b1, 1'b1, 2'b10);
      chk("R10 min floor min", last_y, 8'h01);
      do_op(6'h20, 6'd5, 1'b1, 1'b1, 2'b11);
      chk("R10 min floor mod 5", last_y, 8'h03);

      // R8: zero divisor, explicit values
      do_op(6'h3B, 6'd0, 1'b1, 1'b1, 2'b00);
      chk("R8 neg by zero trunc", last_y, 8'h01);
      do_op(6'h3B, 6'd0, 1'b1, 1'b1, 2'b10);
      chk("R8 neg by zero floor", last_y, 8'h00);
      do_op(6'd9, 6'd0, 1'b0, 1'b0, 2'b10);
      chk("R8 unsigned by zero", last_y, 8'h3F);

      // R1: mixed flags behave as unsigned
      do_op(6'h3C, 6'd5, 1'b1, 1'b0, 2'b00);
      chk("R1 mixed flags", last_y, 8'h0C);

      // Exhaustive signed sweep over every mode (R3 R4 R5 R6 R8 R10)
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < (1 << A_W); i++) begin
            for (int j = 0; j < (1 << B_W); j++) begin
               if (j == 0)                           tag = "R8";
               else if (i == 32 || j == 32)          tag = "R10";
               else if (m == 0)                      tag = "R3";
               else if (m == 1)                      tag = "R4";
               else if (m == 2)                      tag = "R5";
               else                                  tag = "R6";
               op_chk(tag, A_W'(i), B_W'(j), 1'b1, 1'b1, 2'(m));
            end
         end
      end

      // Random flags and modes (R1 R7)
      for (int k = 0; k < 600; k++) begin
         logic [A_W-1:0] ra;
         logic [B_W-1:0] rb;
         logic [1:0]     rm;
         logic           rsa, rsb;
         ra  = A_W'($urandom);
         rb  = B_W'($urandom);
         rm  = 2'($urandom);
         rsa = 1'($urandom);
         rsb = 1'($urandom);
         if (rsa && rsb)      tag = "R9";
         else if (rsa || rsb) tag = "R1";
         else                 tag = "R7";
         op_chk(tag, ra, rb, rsa, rsb, rm);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule